// File: doc/BRIEF.md
# Loop Iteration Admission Gate

This block caps how many iterations of one loop may be in flight at the same time in a dynamic, token-driven execution engine. It keeps a pool of admission credits sized by a configurable limit K. A new iteration asks to start, and it receives a grant only if a credit can be given to it. The grant takes one credit from the pool. When the last operation of an iteration finishes, a completion pulse puts the credit back, so a waiting iteration can start in its place.

The limit is sampled from an input when reset is active or when the clear input is high. After that, changes on the limit input have no effect until the next reset or clear. The block reports how many iterations are in flight and how many credits are free. It flags a completion pulse that arrives while nothing is in flight, and that stray pulse never adds a credit. The grant is combinational, so an iteration can start in the same cycle as its request. A completion in that same cycle frees a credit that the grant may use at once.

Top module: `iterThrottle`

## Requirements
- R1: While rstN is low, or in a cycle where clear is high, the limit input is captured. From the next cycle, activeCount is 0 and tokensFree equals the captured limit.
- R2: When startReq is high, clear is low and tokensFree is non-zero, startGrant is high in the same cycle and activeCount rises by one in the next cycle, unless a valid completion also occurs.
- R3: When startReq is high, tokensFree is 0 and iterDone is low, startGrant stays low and activeCount is unchanged.
- R4: activeCount never exceeds the captured limit.
- R5: An iterDone pulse while activeCount is non-zero, with no grant in the same cycle, lowers activeCount by one in the next cycle.
- R6: When startReq and iterDone are both high with activeCount non-zero, startGrant is high even if tokensFree is 0, and activeCount is unchanged in the next cycle.
- R7: An iterDone pulse while activeCount is 0 drives doneError high in that cycle, and activeCount and tokensFree stay unchanged.
- R8: Changes on limitK while clear is low and rstN is high do not change the captured limit.
- R9: activeCount plus tokensFree always equals the captured limit.
- R10: In a cycle with clear high, startGrant and doneError are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; captures limitK |
| clear | input | 1 | Synchronous re-initialise; captures limitK and empties the in-flight set |
| limitK | input | CW | Maximum number of concurrent iterations |
| startReq | input | 1 | An iteration asks to enter the loop |
| startGrant | output | 1 | Entry granted this cycle; one credit is taken |
| iterDone | input | 1 | An iteration finished; one credit is returned |
| doneError | output | 1 | iterDone arrived with no iteration in flight |
| activeCount | output | CW | Iterations currently in flight |
| tokensFree | output | CW | Credits currently in the pool |

## Verification
An entry request and a completion pulse can arrive in the same cycle. This case matters most when the pool is empty, because the grant then depends on the credit being returned. Random stimulus raises both inputs often while the in-flight count sits at the limit. Directed sequences first fill the pool and then fire both inputs together. The bench expects a grant in that cycle and an unchanged count in the next cycle. It also drives a completion at zero count, and a clear together with both inputs, and expects doneError and the grant as the requirements state.

// File: rtl/iterThrottlePkg.sv
package iterThrottlePkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic load;  // capture limit, empty in-flight set
    logic take;  // one credit leaves the pool
    logic give;  // one credit returns to the pool
  } throttleStrobe_t;
endpackage

// File: rtl/iterThrottleCtrl.sv
module iterThrottleCtrl
  import iterThrottlePkg::*;
(
  input  logic            rstN,
  input  logic            clear,
  input  logic            startReq,
  input  logic            iterDone,
  input  logic            creditAvail,
  input  logic            anyActive,
  output logic            startGrant,
  output logic            doneError,
  output throttleStrobe_t strobe
);
  logic loadNow;
  logic doneOk;

  always_comb begin
    loadNow    = clear || !rstN;
    doneOk     = !loadNow && iterDone && anyActive;
    doneError  = !loadNow && iterDone && !anyActive;
    // a credit returned this cycle may be reused by a same-cycle entry
    startGrant = !loadNow && startReq && (creditAvail || doneOk);
    strobe.load = loadNow;
    strobe.take = startGrant;
    strobe.give = doneOk;
  end
endmodule

// File: rtl/iterThrottleData.sv
module iterThrottleData
  import iterThrottlePkg::*;
#(
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic [CW-1:0]   limitK,
  input  throttleStrobe_t strobe,
  output logic [CW-1:0]   activeCount,
  output logic [CW-1:0]   tokensFree,
  output logic            creditAvail,
  output logic            anyActive
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] kReg;
  logic [CW-1:0] actReg;
  logic [CW-1:0] actNext;

  always_comb begin
    actNext = actReg;
    unique case ({strobe.take, strobe.give})
      2'b10:   actNext = actReg + ONE;
      2'b01:   actNext = actReg - ONE;
      default: actNext = actReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      kReg   <= limitK;
      actReg <= '0;
    end else begin
      actReg <= actNext;
    end
  end

  assign activeCount = actReg;
  assign tokensFree  = kReg - actReg;
  assign creditAvail = (tokensFree != '0);
  assign anyActive   = (actReg != '0);
endmodule

// File: rtl/iterThrottle.sv
module iterThrottle
  import iterThrottlePkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic [CW-1:0] limitK,
  input  logic          startReq,
  output logic          startGrant,
  input  logic          iterDone,
  output logic          doneError,
  output logic [CW-1:0] activeCount,
  output logic [CW-1:0] tokensFree
);
  throttleStrobe_t strobe;
  logic creditAvail;
  logic anyActive;

  iterThrottleCtrl ctrl (
    .rstN        (rstN),
    .clear       (clear),
    .startReq    (startReq),
    .iterDone    (iterDone),
    .creditAvail (creditAvail),
    .anyActive   (anyActive),
    .startGrant  (startGrant),
    .doneError   (doneError),
    .strobe      (strobe)
  );

  iterThrottleData #(.CW(CW)) data (
    .clk         (clk),
    .limitK      (limitK),
    .strobe      (strobe),
    .activeCount (activeCount),
    .tokensFree  (tokensFree),
    .creditAvail (creditAvail),
    .anyActive   (anyActive)
  );
endmodule

// File: rtl/iterThrottleChecker.sv
module iterThrottleChecker #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          clear,
  input logic [CW-1:0] limitK,
  input logic          startReq,
  input logic          startGrant,
  input logic          iterDone,
  input logic          doneError,
  input logic [CW-1:0] activeCount,
  input logic [CW-1:0] tokensFree
);
  logic [CW-1:0] kShadow;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rstN || clear) kShadow <= limitK;
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN || !armed)
    activeCount <= kShadow); // R4
  AST_CREDIT_SUM: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (activeCount + tokensFree) == kShadow); // R9
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (startReq && tokensFree == '0 && !iterDone) |-> !startGrant); // R3
  AST_GRANT_COUNTS: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (startGrant && !iterDone && !clear) |=> activeCount == $past(activeCount) + CW'(1)); // R2
  AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (startReq && iterDone && activeCount != '0 && !clear) |-> startGrant); // R6
  AST_SWAP_STABLE: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (startGrant && iterDone && activeCount != '0 && !clear) |=> $stable(activeCount)); // R6
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (iterDone && activeCount == '0 && !clear) |-> doneError); // R7
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> (!startGrant && !doneError)); // R10
endmodule

bind iterThrottle iterThrottleChecker #(.CW(CW)) chk (.*);

// File: tb/iterThrottle_test.sv
module iterThrottle_test;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          clear;
  logic [CW-1:0] limitK;
  logic          startReq;
  logic          startGrant;
  logic          iterDone;
  logic          doneError;
  logic [CW-1:0] activeCount;
  logic [CW-1:0] tokensFree;

  int checks = 0;
  int failures = 0;
  int mK = 0;
  int mAct = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  iterThrottle #(.CW(CW)) uut (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit expGrant(bit req, bit dn, bit clr);
    return !clr && req && ((mAct < mK) || (dn && mAct > 0));
  endfunction

  function automatic bit expErr(bit dn, bit clr);
    return !clr && dn && (mAct == 0);
  endfunction

  // drive one cycle at negedge, check, advance model
  task automatic step(bit req, bit dn, bit clr, int lim);
    bit g;
    bit e;
    @(negedge clk);
    startReq = req; iterDone = dn; clear = clr; limitK = CW'(lim);
    #1;
    check("R4 activeCount", int'(activeCount), mAct);
    check("R9 tokensFree", int'(tokensFree), mK - mAct);
    g = expGrant(req, dn, clr);
    e = expErr(dn, clr);
    if (clr)                         check("R10 startGrant", int'(startGrant), 0);
    else if (req && dn && mAct == mK && mK > 0) check("R6 startGrant", int'(startGrant), int'(g));
    else if (req && mAct >= mK)      check("R3 startGrant", int'(startGrant), int'(g));
    else                             check("R2 startGrant", int'(startGrant), int'(g));
    if (clr) check("R10 doneError", int'(doneError), 0);
    else     check("R7 doneError", int'(doneError), int'(e));
    if (clr) begin
      mK = lim; mAct = 0;
    end else begin
      mAct = mAct + int'(g) - int'(dn && mAct > 0);
    end
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; clear = 1'b0; startReq = 1'b0; iterDone = 1'b0; limitK = CW'(3);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mK = 3; mAct = 0;
    #1;
    check("R1 reset activeCount", int'(activeCount), 0);
    check("R1 reset tokensFree", int'(tokensFree), 3);

    // R7 stray done at empty
    step(0, 1, 0, 3);
    // R2 fill pool to limit, R8 limit input wiggles
    step(1, 0, 0, 9);
    step(1, 0, 0, 1);
    step(1, 0, 0, 15);
    // R3 pool empty
    step(1, 0, 0, 3);
    // R6 swap at full pool
    step(1, 1, 0, 3);
    step(1, 1, 0, 3);
    // R5 drain
    step(0, 1, 0, 3);
    step(0, 1, 0, 3);
    step(0, 1, 0, 3);
    step(0, 1, 0, 3);
    check("R8 captured limit kept", int'(tokensFree), 3);
    // R10 clear together with both inputs
    step(1, 1, 1, 1);
    step(1, 0, 0, 1);
    step(1, 0, 0, 1);
    step(0, 0, 0, 1);
    check("R1 clear limit", int'(activeCount) + int'(tokensFree), 1);
    // K = 0: nothing enters
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    // random phase
    step(0, 0, 1, 5);
    for (int i = 0; i < 4000; i++) begin
      bit r = ($urandom % 4) != 0;
      bit d = ($urandom % 3) == 0;
      bit c = ($urandom % 97) == 0;
      int l = int'($urandom % 16);
      step(r, d, c, l);
    end
    step(0, 0, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule